// File: doc/BRIEF.md
# Wide Vector Micro-op Sequencer

This block executes one 1024-bit vector micro-op as four back-to-back passes over a single 256-bit execution lane. The micro-op is captured once, at its handshake, together with four sets of physical register numbers (two sources and one destination per set). It is then replayed on the lane, once per pass. Only the register numbers change from one pass to the next. The opcode and tag stay fixed. A 256-bit micro-op takes the same path but finishes after one pass.

The lane returns a small exception flag vector for each pass. For a wide micro-op, the flags of the early passes are parked in per-pass slices. Nothing reaches the reorder-buffer status port until the final pass. On that cycle the whole four-slice status vector, the tag and a summary exception bit are presented in one write. Between writes the status port is driven to zero and can stay gated. A synchronous flush abandons a sequence in flight, and that sequence writes nothing.

Top module: `wvec_seq`

## Requirements
- R1: After reset, `uop_ready_o` is 1 and neither `lane_issue_o` nor `wb_valid_o` is asserted.
- R2: A micro-op is accepted on a clock edge where `uop_valid_i` and `uop_ready_o` are both 1. `uop_ready_o` stays 0 through every issue cycle of that micro-op and returns to 1 in the cycle after its final pass.
- R3: On pass k (k = 0..3, shown on `lane_pass_o`), the lane source A, source B and destination outputs carry register set k. Set k sits at bits [k*PREG_W +: PREG_W] of each packed input. `lane_opc_o` equals the accepted opcode on every pass.
- R4: `uop_wide_i` = 1 marks a 1024-bit micro-op, which issues on the four consecutive cycles after its acceptance edge. `uop_wide_i` = 0 marks a 256-bit micro-op, which issues once, in the cycle after acceptance, as pass 0.
- R5: `wb_valid_o` is asserted exactly once per completed micro-op, in the cycle of its final pass, and never on an earlier pass.
- R6: For a wide micro-op, slice k of `wb_status_o` (bits [k*FLAG_W +: FLAG_W]) equals the `lane_flags_i` value presented during pass k. Slice 3 is taken from the flags of the writeback cycle itself.
- R7: For a 256-bit micro-op, slice 0 of `wb_status_o` equals the flags of its single pass and slices 1 to 3 are zero. Whenever `wb_valid_o` is 0, `wb_status_o` is zero.
- R8: During a writeback, `wb_exc_o` is the OR of all bits of `wb_status_o` and `wb_tag_o` equals the accepted tag.
- R9: In a cycle with `flush_i` = 1, no pass is issued, no writeback is made and no micro-op is accepted. The sequence in flight is dropped, and `uop_ready_o` is 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous abort of the sequence in flight |
| uop_valid_i | input | 1 | Micro-op offered |
| uop_ready_o | output | 1 | Sequencer can take a micro-op |
| uop_wide_i | input | 1 | 1: 1024-bit (four passes), 0: 256-bit (one pass) |
| uop_opc_i | input | OPC_W | Opcode |
| uop_tag_i | input | TAG_W | Reorder-buffer tag |
| uop_src_a_i | input | 4*PREG_W | Source A register sets, set k at [k*PREG_W +: PREG_W] |
| uop_src_b_i | input | 4*PREG_W | Source B register sets |
| uop_dst_i | input | 4*PREG_W | Destination register sets |
| lane_issue_o | output | 1 | A pass is issued to the lane this cycle |
| lane_pass_o | output | 2 | Pass index |
| lane_opc_o | output | OPC_W | Opcode for the lane |
| lane_src_a_o | output | PREG_W | Source A register of this pass |
| lane_src_b_o | output | PREG_W | Source B register of this pass |
| lane_dst_o | output | PREG_W | Destination register of this pass |
| lane_flags_i | input | FLAG_W | Exception flags of the pass issued this cycle |
| wb_valid_o | output | 1 | Status write to the reorder buffer |
| wb_tag_o | output | TAG_W | Tag of the completing micro-op |
| wb_exc_o | output | 1 | OR of all status bits |
| wb_status_o | output | 4*FLAG_W | Per-pass exception status slices |

## Verification
A micro-op accepted on edge T issues pass k in the cycle between edges T+k and T+k+1. The lane outputs come from registers, so they settle just after the edge. The writeback is combinational on the final pass and uses that cycle's flags, so it is due in that same cycle. `uop_ready_o` returns one cycle after the final pass. The bench changes inputs on the falling edge, waits a short delay and then samples. Each pass is therefore checked in its own cycle, with that pass's flags already applied. A flush is checked both in the cycle it is asserted and in the cycle after.

// File: rtl/wvec_pkg.sv
package wvec_pkg;
  localparam int unsigned NUM_PASS = 4;
  localparam int unsigned PASS_W   = $clog2(NUM_PASS);
endpackage

// File: rtl/wvec_pass_ctrl.sv
module wvec_pass_ctrl
  import wvec_pkg::*;
#(
  parameter int unsigned PREG_W = 8,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned OPC_W  = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       uop_valid_i,
  output logic                       uop_ready_o,
  input  logic                       uop_wide_i,
  input  logic [OPC_W-1:0]           uop_opc_i,
  input  logic [TAG_W-1:0]           uop_tag_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_src_a_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_src_b_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_dst_i,
  output logic                       lane_issue_o,
  output logic [PASS_W-1:0]          lane_pass_o,
  output logic [OPC_W-1:0]           lane_opc_o,
  output logic [PREG_W-1:0]          lane_src_a_o,
  output logic [PREG_W-1:0]          lane_src_b_o,
  output logic [PREG_W-1:0]          lane_dst_o,
  output logic                       last_o,
  output logic                       wide_o,
  output logic [TAG_W-1:0]           tag_o
);
  localparam int unsigned SET_W = NUM_PASS * PREG_W;

  logic              busy_q, wide_q;
  logic [PASS_W-1:0] pass_q;
  logic [OPC_W-1:0]  opc_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SET_W-1:0]  src_a_q, src_b_q, dst_q;
  logic              accept;

  logic [PREG_W-1:0] a_set [NUM_PASS];
  logic [PREG_W-1:0] b_set [NUM_PASS];
  logic [PREG_W-1:0] d_set [NUM_PASS];

  assign uop_ready_o  = !busy_q && !flush_i;
  assign accept       = uop_valid_i && uop_ready_o;
  assign lane_issue_o = busy_q && !flush_i;
  assign last_o       = wide_q ? (pass_q == PASS_W'(NUM_PASS - 1)) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      wide_q  <= 1'b0;
      pass_q  <= '0;
      opc_q   <= '0;
      tag_q   <= '0;
      src_a_q <= '0;
      src_b_q <= '0;
      dst_q   <= '0;
    end else if (flush_i) begin
      busy_q <= 1'b0;
      pass_q <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      pass_q  <= '0;
      wide_q  <= uop_wide_i;
      opc_q   <= uop_opc_i;
      tag_q   <= uop_tag_i;
      src_a_q <= uop_src_a_i;
      src_b_q <= uop_src_b_i;
      dst_q   <= uop_dst_i;
    end else if (lane_issue_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        pass_q <= '0;
      end else begin
        pass_q <= pass_q + 1'b1;
      end
    end
  end

  // per-pass register sets
  for (genvar k = 0; k < NUM_PASS; k++) begin : g_set
    assign a_set[k] = src_a_q[k*PREG_W +: PREG_W];
    assign b_set[k] = src_b_q[k*PREG_W +: PREG_W];
    assign d_set[k] = dst_q[k*PREG_W +: PREG_W];
  end

  assign lane_pass_o  = pass_q;
  assign lane_opc_o   = opc_q;
  assign lane_src_a_o = a_set[pass_q];
  assign lane_src_b_o = b_set[pass_q];
  assign lane_dst_o   = d_set[pass_q];
  assign wide_o       = wide_q;
  assign tag_o        = tag_q;

  a_r2_busy_not_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_issue_o |-> !uop_ready_o);

  a_r4_first_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uop_valid_i && uop_ready_o) ##1 !flush_i |-> lane_issue_o && lane_pass_o == '0);

  a_r4_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_issue_o && !last_o) ##1 !flush_i |->
      lane_issue_o && lane_pass_o == PASS_W'($past(lane_pass_o) + 1'b1));

  a_r3_opc_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_issue_o && !last_o) ##1 !flush_i |-> $stable(lane_opc_o));

  a_r9_flush_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lane_issue_o);
endmodule

// File: rtl/wvec_status_acc.sv
module wvec_status_acc
  import wvec_pkg::*;
#(
  parameter int unsigned FLAG_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       issue_i,
  input  logic                       wide_i,
  input  logic                       last_i,
  input  logic [PASS_W-1:0]          pass_i,
  input  logic [FLAG_W-1:0]          flags_i,
  output logic                       wb_valid_o,
  output logic [NUM_PASS*FLAG_W-1:0] wb_status_o,
  output logic                       wb_exc_o
);
  localparam int unsigned ST_W = NUM_PASS * FLAG_W;

  logic [FLAG_W-1:0] slice_q [NUM_PASS-1];
  logic [ST_W-1:0]   status_raw;

  // early-pass slices: written only on their own wide pass, idle otherwise
  for (genvar k = 0; k < NUM_PASS - 1; k++) begin : g_slice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        slice_q[k] <= '0;
      else if (issue_i && wide_i && pass_i == PASS_W'(k))
        slice_q[k] <= flags_i;
    end

    if (k == 0) begin : g_low
      assign status_raw[k*FLAG_W +: FLAG_W] = wide_i ? slice_q[k] : flags_i;
    end else begin : g_mid
      assign status_raw[k*FLAG_W +: FLAG_W] = wide_i ? slice_q[k] : '0;
    end
  end

  assign status_raw[(NUM_PASS-1)*FLAG_W +: FLAG_W] = wide_i ? flags_i : '0;

  assign wb_valid_o  = issue_i && last_i;
  assign wb_status_o = status_raw & {ST_W{wb_valid_o}};
  assign wb_exc_o    = |wb_status_o;

  a_r5_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !wb_valid_o);

  a_r7_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_valid_o && !wide_i) |-> wb_status_o[ST_W-1:FLAG_W] == '0);
endmodule

// File: rtl/wvec_seq.sv
module wvec_seq
  import wvec_pkg::*;
#(
  parameter int unsigned PREG_W = 8,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned OPC_W  = 8,
  parameter int unsigned FLAG_W = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       flush_i,
  input  logic                       uop_valid_i,
  output logic                       uop_ready_o,
  input  logic                       uop_wide_i,
  input  logic [OPC_W-1:0]           uop_opc_i,
  input  logic [TAG_W-1:0]           uop_tag_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_src_a_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_src_b_i,
  input  logic [NUM_PASS*PREG_W-1:0] uop_dst_i,
  output logic                       lane_issue_o,
  output logic [PASS_W-1:0]          lane_pass_o,
  output logic [OPC_W-1:0]           lane_opc_o,
  output logic [PREG_W-1:0]          lane_src_a_o,
  output logic [PREG_W-1:0]          lane_src_b_o,
  output logic [PREG_W-1:0]          lane_dst_o,
  input  logic [FLAG_W-1:0]          lane_flags_i,
  output logic                       wb_valid_o,
  output logic [TAG_W-1:0]           wb_tag_o,
  output logic                       wb_exc_o,
  output logic [NUM_PASS*FLAG_W-1:0] wb_status_o
);
  logic              last;
  logic              wide;
  logic [TAG_W-1:0]  tag;

  wvec_pass_ctrl #(
    .PREG_W (PREG_W),
    .TAG_W  (TAG_W),
    .OPC_W  (OPC_W)
  ) u_pass_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .uop_valid_i  (uop_valid_i),
    .uop_ready_o  (uop_ready_o),
    .uop_wide_i   (uop_wide_i),
    .uop_opc_i    (uop_opc_i),
    .uop_tag_i    (uop_tag_i),
    .uop_src_a_i  (uop_src_a_i),
    .uop_src_b_i  (uop_src_b_i),
    .uop_dst_i    (uop_dst_i),
    .lane_issue_o (lane_issue_o),
    .lane_pass_o  (lane_pass_o),
    .lane_opc_o   (lane_opc_o),
    .lane_src_a_o (lane_src_a_o),
    .lane_src_b_o (lane_src_b_o),
    .lane_dst_o   (lane_dst_o),
    .last_o       (last),
    .wide_o       (wide),
    .tag_o        (tag)
  );

  wvec_status_acc #(
    .FLAG_W (FLAG_W)
  ) u_status_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (lane_issue_o),
    .wide_i      (wide),
    .last_i      (last),
    .pass_i      (lane_pass_o),
    .flags_i     (lane_flags_i),
    .wb_valid_o  (wb_valid_o),
    .wb_status_o (wb_status_o),
    .wb_exc_o    (wb_exc_o)
  );

  assign wb_tag_o = wb_valid_o ? tag : '0;

  a_r5_wb_on_issue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> lane_issue_o && !uop_ready_o);

  a_r9_flush_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> !wb_valid_o && !lane_issue_o && !uop_ready_o);

  a_r8_exc_needs_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_exc_o |-> wb_valid_o);
endmodule

// File: tb/wvec_seq_bench.sv
`timescale 1ns/1ps
module wvec_seq_bench;
  localparam int PREG_W = 8;
  localparam int TAG_W  = 6;
  localparam int OPC_W  = 8;
  localparam int FLAG_W = 5;
  localparam int NP     = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic flush_i = 1'b0;
  logic uop_valid_i = 1'b0;
  logic uop_ready_o;
  logic uop_wide_i = 1'b0;
  logic [OPC_W-1:0] uop_opc_i = '0;
  logic [TAG_W-1:0] uop_tag_i = '0;
  logic [NP*PREG_W-1:0] uop_src_a_i = '0, uop_src_b_i = '0, uop_dst_i = '0;
  logic lane_issue_o;
  logic [1:0] lane_pass_o;
  logic [OPC_W-1:0] lane_opc_o;
  logic [PREG_W-1:0] lane_src_a_o, lane_src_b_o, lane_dst_o;
  logic [FLAG_W-1:0] lane_flags_i = '0;
  logic wb_valid_o;
  logic [TAG_W-1:0] wb_tag_o;
  logic wb_exc_o;
  logic [NP*FLAG_W-1:0] wb_status_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [FLAG_W-1:0] fl [NP];

  always #2.5 clk_i = ~clk_i;

  wvec_seq u_wvec_seq (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [NP*FLAG_W-1:0] exp_status(input bit wide);
    logic [NP*FLAG_W-1:0] s = '0;
    for (int k = 0; k < NP; k++)
      if (wide || k == 0) s[k*FLAG_W +: FLAG_W] = fl[k];
    return s;
  endfunction

  // flag_mode: 0 random, 1 all zero, 2 only pass 0 set
  task automatic run_op(input bit wide, input int flush_at, input int flag_mode);
    logic [NP*FLAG_W-1:0] es;
    int n;
    @(negedge clk_i);
    #1 chk("R2 ready before offer", uop_ready_o, 1);
    uop_wide_i  = wide;
    uop_opc_i   = OPC_W'($urandom);
    uop_tag_i   = TAG_W'($urandom);
    uop_src_a_i = $urandom;
    uop_src_b_i = $urandom;
    uop_dst_i   = $urandom;
    uop_valid_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    uop_valid_i = 1'b0;
    n = wide ? NP : 1;
    for (int p = 0; p < n; p++) begin
      case (flag_mode)
        1: fl[p] = '0;
        2: fl[p] = (p == 0) ? '1 : '0;
        default: fl[p] = ($urandom % 2) ? FLAG_W'($urandom) : '0;
      endcase
      lane_flags_i = fl[p];
      if (p == flush_at) begin
        flush_i = 1'b1;
        #1;
        chk("R9 no issue on flush", lane_issue_o, 0);
        chk("R9 no wb on flush", wb_valid_o, 0);
        chk("R9 no accept on flush", uop_ready_o, 0);
        @(posedge clk_i);
        @(negedge clk_i);
        flush_i = 1'b0;
        #1;
        chk("R9 ready after flush", uop_ready_o, 1);
        chk("R9 idle after flush", lane_issue_o, 0);
        return;
      end
      #1;
      chk("R4 issue", lane_issue_o, 1);
      chk("R3 pass index", lane_pass_o, p);
      chk("R3 src a", lane_src_a_o, uop_src_a_i[p*PREG_W +: PREG_W]);
      chk("R3 src b", lane_src_b_o, uop_src_b_i[p*PREG_W +: PREG_W]);
      chk("R3 dst", lane_dst_o, uop_dst_i[p*PREG_W +: PREG_W]);
      chk("R3 opcode", lane_opc_o, uop_opc_i);
      chk("R2 ready low busy", uop_ready_o, 0);
      chk("R5 wb only on last", wb_valid_o, (p == n - 1));
      if (p == n - 1) begin
        es = exp_status(wide);
        chk(wide ? "R6 wide status" : "R7 narrow status", wb_status_o, es);
        chk("R8 exc summary", wb_exc_o, |es);
        chk("R8 tag", wb_tag_o, uop_tag_i);
      end else begin
        chk("R7 status quiet", wb_status_o, 0);
      end
      @(posedge clk_i);
      @(negedge clk_i);
    end
    #1;
    chk("R2 ready after last", uop_ready_o, 1);
    chk("R4 no extra issue", lane_issue_o, 0);
    chk("R5 no extra wb", wb_valid_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    chk("R1 ready after reset", uop_ready_o, 1);
    chk("R1 no issue after reset", lane_issue_o, 0);
    chk("R1 no wb after reset", wb_valid_o, 0);

    run_op(1'b1, -1, 1);  // wide, clean: exc 0
    run_op(1'b1, -1, 2);  // wide, only slice 0 set
    run_op(1'b0, -1, 2);  // narrow with flags
    run_op(1'b0, -1, 0);
    run_op(1'b1, 2, 0);   // flush mid-sequence
    run_op(1'b1, 0, 0);   // flush on first pass
    run_op(1'b0, 0, 0);   // flush narrow
    run_op(1'b1, 3, 0);   // flush on final pass
    run_op(1'b1, -1, 0);  // wide after flushes: fresh slices

    // R9: offer during flush is not taken
    @(negedge clk_i);
    uop_valid_i = 1'b1;
    flush_i = 1'b1;
    #1 chk("R9 ready low during flush", uop_ready_o, 0);
    @(posedge clk_i);
    @(negedge clk_i);
    uop_valid_i = 1'b0;
    flush_i = 1'b0;
    #1 chk("R9 offer under flush dropped", lane_issue_o, 0);

    for (int i = 0; i < 60; i++)
      run_op(1'($urandom), ($urandom % 8 == 0) ? int'($urandom % 4) : -1, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule